// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This core executes one instruction per clock from a six-instruction subset: unsigned add, unsigned subtract, OR with an immediate, word load, word store and branch-on-equal. It holds the program counter, a 32 x 32-bit register file with two read ports and one write port, an immediate extender, an ALU, next-PC logic, and two 256-word internal memories. The instruction memory and the data memory both read combinationally. The data memory and the register file write on the same rising edge that advances the PC.

A host fills the instruction memory through a program-load port while it holds reset. When reset is released, the core runs from address 0. Every architectural update is brought out on trace ports while the instruction that causes it is current. An observer can therefore follow each register write, each memory write and each PC value without reaching into the core.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, all 32 registers and every data-memory word are cleared to zero. No architectural write is committed during reset.
- R2: Instruction fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Op 0x00 with funct 0x21 writes R[rd] = R[rs] + R[rt]. Op 0x00 with funct 0x23 writes R[rd] = R[rs] - R[rt]. Both wrap modulo 2^32.
- R3: Op 0x0D writes R[rt] = R[rs] OR the immediate in bits 15:0, zero-extended to 32 bits.
- R4: Op 0x23 writes R[rt] with the data word at R[rs] + sign-extended immediate. The word index is bits 9:2 of that address, and all other address bits are ignored.
- R5: Op 0x2B writes R[rt] into the data word at the same address as R4. It writes no register.
- R6: Op 0x04 sets PC to PC+4 + (sign-extended immediate << 2) when R[rs] == R[rt], and to PC+4 otherwise. It writes neither a register nor memory.
- R7: Every instruction other than a taken branch advances the PC by exactly 4.
- R8: Register 0 always reads as zero. A write aimed at it is dropped, and `rf_we_o` stays low for it.
- R9: Any other opcode, and any op 0x00 funct other than 0x21 or 0x23, is a no-op. It writes nothing, and the PC advances by 4.
- R10: The instruction is fetched from word PC[9:2], so the fetch wraps every 1 KiB. A rising edge with `prog_we` high stores `prog_data` at instruction word `prog_addr`.
- R11: The trace ports show, during the cycle of the current instruction, the register write and the memory write that the next rising edge commits. A store never raises `rf_we_o`, and a non-store never raises `dm_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program-load write enable |
| prog_addr | input | 8 | Instruction word index to load |
| prog_data | input | 32 | Instruction word to load |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value written to that register |
| dm_we_o | output | 1 | A data-memory write commits at the next edge |
| dm_addr_o | output | 32 | Effective byte address of the load or store |
| dm_wdata_o | output | 32 | Store data |

## Verification
Single-cycle timing shortens the path from a fault to the ports. A wrong register, memory word or PC becomes visible the first time a later instruction reads it. A wrong register or memory word shows up as a mismatched `rf_wdata_o`, `dm_wdata_o` or `dm_addr_o`, and a wrong PC shows up directly on `pc_o`. A wrong next-PC therefore appears one cycle later on `pc_o` and then desynchronises every later trace value. A corrupted register shows up only when it is next used as a source, so the random programs use a small pool of registers to keep reuse distances short. Branches in those programs compare registers that often hold equal values.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int IMM_W  = 16;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    use_imm;
    logic    zero_ext;
    logic    mem_we;
    logic    wb_from_mem;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;

  // Widen a 16-bit immediate by zero or sign fill.
  function automatic logic [XLEN-1:0] extend_imm(input logic [IMM_W-1:0] imm,
                                                 input logic zext);
    logic fill;
    fill = zext ? 1'b0 : imm[IMM_W-1];
    return {{(XLEN-IMM_W){fill}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input alu_op_e op);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  // Branch target: sequential PC plus word-scaled signed offset.
  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc_seq,
                                                    input logic [IMM_W-1:0] imm);
    logic [XLEN-1:0] wide;
    wide = extend_imm(imm, 1'b0);
    return pc_seq + {wide[XLEN-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic       known
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    known       = 1'b1;
    case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADDU || funct == FN_SUBU) begin
          ctrl.reg_we    = 1'b1;
          ctrl.dst_is_rd = 1'b1;
          ctrl.alu_op    = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end else begin
          known = 1'b0;
        end
      end
      OP_ORI: begin
        ctrl.reg_we   = 1'b1;
        ctrl.use_imm  = 1'b1;
        ctrl.zero_ext = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      OP_LW: begin
        ctrl.reg_we      = 1'b1;
        ctrl.use_imm     = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: known = 1'b0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] regs_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else if (we && wa != '0) begin
      regs_q[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

  // R8: the zero register is never changed after reset
  assert_zero_reg_held_R8: assert property (@(posedge clk) disable iff (rst)
    regs_q[0] == '0);

  // R11: a traced register write lands at the next edge
  assert_reg_write_lands_R11: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs_q[$past(wa)] == $past(wd));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  assign y  = alu_eval(a, b, op);
  assign eq = (a == b);

  // R6: the equality flag agrees with a zero difference
  always_comb begin
    if (op == ALU_SUB) begin
      assert_eq_vs_diff_R6: assert ((y == '0) == eq);
    end
  end

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc
  import sc_pkg::*;
(
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  logic             take,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  pc_next
);

  logic [XLEN-1:0] pc_seq;

  assign pc_seq  = pc + XLEN'(4);
  assign target  = branch_target(pc_seq, imm);
  assign pc_next = take ? target : pc_seq;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [XLEN-1:0]    prog_data,
  output logic [XLEN-1:0]    pc_o,
  output logic               rf_we_o,
  output logic [REG_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               dm_we_o,
  output logic [XLEN-1:0]    dm_addr_o,
  output logic [XLEN-1:0]    dm_wdata_o
);

  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  // Instruction memory: loaded from outside, read combinationally
  logic [XLEN-1:0] imem_q [IMEM_WORDS];

  always_ff @(posedge clk) begin
    if (prog_we) imem_q[prog_addr] <= prog_data;
  end

  // Program counter
  logic [XLEN-1:0] pc_q, pc_next, br_target;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  logic [XLEN-1:0] instr;
  assign instr = imem_q[pc_q[IMEM_AW+1:2]];

  logic [5:0]        f_op, f_fn;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd;
  logic [IMM_W-1:0]  f_imm;

  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  ctrl_t ctrl;
  logic  known;

  sc_decode u_decode (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl),
    .known  (known)
  );

  // Named internal events
  logic              commit_reg, commit_mem, take_branch, alu_eq;
  logic [REG_AW-1:0] dst;
  logic [XLEN-1:0]   src_a, src_b, imm_ext, alu_b, alu_y, wb_data, dm_rdata;
  logic [DMEM_AW-1:0] dm_idx;

  assign dst = ctrl.dst_is_rd ? f_rd : f_rt;

  sc_regfile #(.DW(XLEN), .AW(REG_AW)) u_regfile (
    .clk  (clk),
    .rst  (rst),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .rd_a (src_a),
    .rd_b (src_b),
    .we   (commit_reg),
    .wa   (dst),
    .wd   (wb_data)
  );

  assign imm_ext = extend_imm(f_imm, ctrl.zero_ext);
  assign alu_b   = ctrl.use_imm ? imm_ext : src_b;

  sc_alu u_alu (
    .a  (src_a),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y),
    .eq (alu_eq)
  );

  assign take_branch = ctrl.is_branch && alu_eq;

  sc_nextpc u_nextpc (
    .pc      (pc_q),
    .imm     (f_imm),
    .take    (take_branch),
    .target  (br_target),
    .pc_next (pc_next)
  );

  // Data memory: combinational read, clocked write, cleared in reset
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  assign dm_idx     = alu_y[DMEM_AW+1:2];
  assign dm_rdata   = dmem_q[dm_idx];
  assign commit_mem = ctrl.mem_we && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] <= '0;
    end else if (commit_mem) begin
      dmem_q[dm_idx] <= src_b;
    end
  end

  assign wb_data    = ctrl.wb_from_mem ? dm_rdata : alu_y;
  assign commit_reg = ctrl.reg_we && (dst != '0) && !rst;

  // Trace ports
  assign pc_o       = pc_q;
  assign rf_we_o    = commit_reg;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = commit_mem;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = src_b;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], alu_y[XLEN-1:DMEM_AW+2], alu_y[1:0],
                         pc_q[XLEN-1:IMEM_AW+2]};

  // R1: the edge after a reset cycle leaves PC at zero
  assert_pc_cleared_R1: assert property (@(posedge clk)
    $past(rst) |-> pc_q == '0);

  // R7: anything but a taken branch steps the PC by one word
  assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
    !take_branch |=> pc_q == $past(pc_q) + XLEN'(4));

  // R6: a taken branch lands on the computed target
  assert_branch_lands_R6: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> pc_q == $past(br_target));

  // R5: a store updates the addressed data word
  assert_store_lands_R5: assert property (@(posedge clk) disable iff (rst)
    commit_mem |=> dmem_q[$past(dm_idx)] == $past(src_b));

  // R9: unrecognised encodings commit nothing
  assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !known |-> !rf_we_o && !dm_we_o);

  // R11: never a register write and a memory write together
  assert_single_commit_R11: assert property (@(posedge clk) disable iff (rst)
    !(rf_we_o && dm_we_o));

  // R10: the PC stays word aligned
  assert_pc_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  always #2 clk = ~clk;

  sc_core u_sc_core (
    .clk        (clk),
    .rst        (rst),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .pc_o       (pc_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .dm_we_o    (dm_we_o),
    .dm_addr_o  (dm_addr_o),
    .dm_wdata_o (dm_wdata_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] prog [256];
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [256];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < 256; i++) m_dm[i] = '0;
    m_pc = '0;
  endtask

  // Compare the trace of the current instruction, then advance the model.
  task automatic step_and_check();
    logic [31:0] w, a, b, wd, addr, dd, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, wa;
    logic [15:0] imm;
    logic        we, dwe;
    string       tag, pctag;
    w = prog[m_pc[9:2]];
    op = w[31:26]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
    fn = w[5:0]; imm = w[15:0];
    a = m_rf[rs]; b = m_rf[rt];
    we = 0; dwe = 0; wa = '0; wd = '0; addr = '0; dd = '0;
    nxt = m_pc + 32'd4;
    tag = "R9";
    pctag = (m_pc[31:10] != 0) ? "R10" : "R7";
    case (op)
      6'h00: begin
        if (fn == 6'h21) begin tag = "R2"; we = 1; wa = rd; wd = a + b; end
        else if (fn == 6'h23) begin tag = "R2"; we = 1; wa = rd; wd = a + ~b + 32'd1; end
      end
      6'h0D: begin tag = "R3"; we = 1; wa = rt; wd = a | {16'h0000, imm}; end
      6'h23: begin tag = "R4"; we = 1; wa = rt; addr = a + sx(imm); wd = m_dm[addr[9:2]]; end
      6'h2B: begin tag = "R5"; dwe = 1; addr = a + sx(imm); dd = b; end
      6'h04: begin
        tag = "R6"; pctag = "R6";
        if (a == b) nxt = m_pc + 32'd4 + (sx(imm) << 2);
      end
      default: tag = "R9";
    endcase
    if (we && wa == 5'd0) begin tag = "R8"; we = 0; end

    chk(pctag, "pc", pc_o, m_pc);
    chk(tag, "rf_we", {31'd0, rf_we_o}, {31'd0, we});
    if (we) begin
      chk(tag, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
      chk(tag, "rf_wdata", rf_wdata_o, wd);
    end
    chk(dwe ? "R5" : "R11", "dm_we", {31'd0, dm_we_o}, {31'd0, dwe});
    if (dwe) begin
      chk("R5", "dm_addr", dm_addr_o, addr);
      chk("R5", "dm_wdata", dm_wdata_o, dd);
    end

    if (we) m_rf[wa] = wd;
    if (dwe) m_dm[addr[9:2]] = dd;
    m_pc = nxt;
  endtask

  // R10: load through the program port while reset is held
  task automatic load_and_run(input int cycles);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 8'(i); prog_data = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "pc in reset", pc_o, 32'h0);
    chk("R1", "no write in reset", {31'd0, rf_we_o | dm_we_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #1;
    for (int c = 0; c < cycles; c++) begin
      step_and_check();
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    int unused_seed;
    int k;
    logic [4:0] r1, r2, r3;
    unused_seed = $urandom(32'd20250310);

    // Directed program
    for (int i = 0; i < 256; i++) prog[i] = '0;
    prog[0]  = enc_r(5'd10, 5'd11, 5'd9, 6'h21);          // R1 regs cleared
    prog[1]  = enc_i(6'h23, 5'd0, 5'd12, 16'h0008);       // R1 memory cleared
    prog[2]  = enc_i(6'h0D, 5'd0, 5'd1, 16'h8005);        // R3 zero-extend
    prog[3]  = enc_i(6'h0D, 5'd0, 5'd2, 16'hFFFC);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd3, 6'h21);            // R2 add
    prog[5]  = enc_r(5'd0, 5'd1, 5'd4, 6'h23);            // R2 sub wraps
    prog[6]  = enc_i(6'h2B, 5'd2, 5'd3, 16'hFFFC);        // R5 negative offset
    prog[7]  = enc_i(6'h23, 5'd2, 5'd5, 16'hFFFC);        // R4 read back
    prog[8]  = enc_r(5'd1, 5'd1, 5'd0, 6'h21);            // R8 write r0 dropped
    prog[9]  = enc_r(5'd0, 5'd0, 5'd6, 6'h21);            // R8 r0 reads zero
    prog[10] = enc_i(6'h04, 5'd3, 5'd5, 16'h0002);        // R6 taken
    prog[11] = enc_i(6'h0D, 5'd0, 5'd7, 16'h0001);
    prog[12] = enc_i(6'h0D, 5'd0, 5'd7, 16'h0002);
    prog[13] = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);        // R6 not taken
    prog[14] = 32'hFC00_0000;                             // R9 unknown op
    prog[15] = enc_r(5'd1, 5'd2, 5'd8, 6'h20);            // R9 unknown funct
    prog[16] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);        // R6 self loop
    load_and_run(24);

    // Random program
    for (int i = 0; i < 256; i++) prog[i] = '0;
    prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'hFFF8);         // R1 memory cleared after reset
    for (int i = 1; i < 128; i++) begin
      k  = int'($urandom_range(0, 9));
      r1 = 5'($urandom_range(0, 7));
      r2 = 5'($urandom_range(0, 7));
      r3 = 5'($urandom_range(0, 7));
      case (k)
        0, 1: prog[i] = enc_r(r1, r2, r3, 6'h21);
        2:    prog[i] = enc_r(r1, r2, r3, 6'h23);
        3:    prog[i] = enc_i(6'h0D, r1, r2, 16'($urandom));
        4:    prog[i] = enc_i(6'h23, r1, r2, 16'($urandom_range(0, 64)) - 16'd32);
        5:    prog[i] = enc_i(6'h2B, r1, r2, 16'($urandom_range(0, 64)) - 16'd32);
        6:    prog[i] = enc_i(6'h2B, r1, r2, 16'($urandom));
        7:    prog[i] = enc_i(6'h04, r1, r2, 16'($urandom_range(0, 12)) - 16'd4);
        8:    prog[i] = enc_r(r1, r2, r3, 6'($urandom_range(0, 31)));
        default: prog[i] = enc_i(6'h3F, r1, r2, 16'($urandom));
      endcase
    end
    load_and_run(3000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule